// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of a 4-bit successive approximation converter. It drives a trial code to an external DAC, reads back a single comparator decision bit, and runs a binary search from the most significant bit down to the least significant bit. When the search is finished it presents the result and raises an end-of-conversion flag.

The controller runs one conversion per reset. Releasing the active-low reset starts a conversion, which takes a fixed five clock cycles. After the flag rises the block freezes, and only a new reset pulse starts the next conversion. The analog input has to be held steady from outside for the whole conversion.

None of the pins carries a stream. The comparator bit, the trial code, the result bus and the flag are all plain level signals, so the block has no valid/ready handshake and no back-pressure. The flag serves as the result's qualifier, and the result stays valid until the next reset.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `rst_n` is low, `trial_o`, `result_o` and `eoc_o` are all zero.
- R2: On the first rising clock edge after `rst_n` goes high, `trial_o` becomes 1000 (only bit 3 set).
- R3: On each of rising edges 2 to 5 after release, bits 3, 2, 1 and 0 are resolved in that order. The bit under test keeps its 1 if `cmp_i` is 1 (input at or above the DAC level) and is cleared if `cmp_i` is 0. The next lower bit is then set to 1. Bits already resolved do not change.
- R4: `eoc_o` is 0 after rising edges 1 to 4 following release and becomes 1 on the fifth edge.
- R5: For an ideal input level held during the conversion, the final result is the largest code whose DAC level does not exceed the input. This covers all 16 codes, including 0000 and 1111.
- R6: `result_o` stays zero until `eoc_o` rises. At that point it holds the final code, with bit 3 as the most significant bit (D3) and bit 0 as D0.
- R7: While `eoc_o` is 1, `trial_o`, `result_o` and `eoc_o` stay constant, and changes on `cmp_i` have no effect.
- R8: The controller never restarts by itself. A new conversion begins only after a fresh low pulse on `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock (nominal 5 MHz, giving a 1 MHz conversion rate) |
| rst_n | input | 1 | Active-low asynchronous reset. Its release starts a conversion |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above the DAC level |
| trial_o | output | 4 | Trial code driven to the external DAC |
| result_o | output | 4 | Conversion result, bit 3 = D3 (MSB) down to bit 0 = D0 |
| eoc_o | output | 1 | End-of-conversion flag |

## Verification
The bench feeds an ideal input level through a comparator model. It sweeps the levels so that every one of the 16 codes is produced, from 0000 to 1111. Some levels sit exactly on a code boundary and others sit half a step above one, which separates a correct "at or above" decision from an off-by-one comparison. One level, 1010, is followed edge by edge to show that the search keeps and clears the right bits. After the flag rises, the comparator is toggled between both extremes to show the result is frozen. A repeated reset with a different level shows that a conversion restarts only on reset.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Phases of the one-shot search
  typedef enum logic [1:0] {
    PH_START  = 2'd0,
    PH_SEARCH = 2'd1,
    PH_DONE   = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int WIDTH = 4,
  parameter int PW    = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          init_o,
  output logic          decide_o,
  output logic          last_o,
  output logic [PW-1:0] ptr_o
);
  import sar_pkg::*;

  localparam logic [PW-1:0] TOP_BIT = PW'(WIDTH - 1);

  sar_phase_e    phase_q;
  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_START;
      ptr_q   <= TOP_BIT;
    end else begin
      case (phase_q)
        PH_START: begin
          phase_q <= PH_SEARCH;
          ptr_q   <= TOP_BIT;
        end
        PH_SEARCH: begin
          if (ptr_q == '0) phase_q <= PH_DONE;
          else             ptr_q   <= ptr_q - 1'b1;
        end
        PH_DONE: phase_q <= PH_DONE;
        default: phase_q <= PH_START;
      endcase
    end
  end

  assign init_o   = (phase_q == PH_START);
  assign decide_o = (phase_q == PH_SEARCH);
  assign last_o   = decide_o && (ptr_q == '0);
  assign ptr_o    = ptr_q;
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int WIDTH = 4,
  parameter int PW    = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             decide_i,
  input  logic [PW-1:0]    ptr_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] code_o,
  output logic [WIDTH-1:0] code_nxt_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic bit_q, bit_d, under_test, next_trial;

    assign under_test = decide_i && (int'(ptr_i) == i);
    assign next_trial = decide_i && (int'(ptr_i) == i + 1);

    always_comb begin
      bit_d = bit_q;
      if (init_i)          bit_d = (i == WIDTH - 1);
      else if (under_test) bit_d = cmp_i;
      else if (next_trial) bit_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= bit_d;
    end

    assign code_o[i]     = bit_q;
    assign code_nxt_o[i] = bit_d;
  end
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [WIDTH-1:0] code_i,
  output logic [WIDTH-1:0] result_o,
  output logic             eoc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      eoc_o    <= 1'b0;
    end else if (capture_i) begin
      result_o <= code_i;
      eoc_o    <= 1'b1;
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] result_o,
  output logic             eoc_o
);
  localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic          init_w, decide_w, last_w;
  logic [PW-1:0] ptr_w;
  logic [WIDTH-1:0] code_nxt_w;

  sar_seq #(.WIDTH(WIDTH), .PW(PW)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_o   (init_w),
    .decide_o (decide_w),
    .last_o   (last_w),
    .ptr_o    (ptr_w)
  );

  sar_trial #(.WIDTH(WIDTH), .PW(PW)) trial_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_w),
    .decide_i   (decide_w),
    .ptr_i      (ptr_w),
    .cmp_i      (cmp_i),
    .code_o     (trial_o),
    .code_nxt_o (code_nxt_w)
  );

  sar_result #(.WIDTH(WIDTH)) res_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (last_w),
    .code_i    (code_nxt_w),
    .result_o  (result_o),
    .eoc_o     (eoc_o)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] trial_o,
  input logic [WIDTH-1:0] result_o,
  input logic             eoc_o
);
  localparam int CW = $clog2(WIDTH + 3) + 1;
  localparam logic [CW-1:0] DONE_AT = CW'(WIDTH + 1);
  localparam logic [CW-1:0] SAT_AT  = CW'(WIDTH + 2);
  localparam logic [WIDTH-1:0] MSB_ONLY = WIDTH'(1) << (WIDTH - 1);

  // edges seen since reset release, saturating
  logic [CW-1:0] edges_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                edges_q <= '0;
    else if (edges_q < SAT_AT) edges_q <= edges_q + 1'b1;
  end

  a_r2_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q == CW'(1)) |-> (trial_o == MSB_ONLY));

  a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q >= CW'(2) && edges_q <= DONE_AT) |->
      ($countones(trial_o ^ $past(trial_o)) <= 2));

  a_r4_eoc_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q >= DONE_AT) == eoc_o);

  a_r6_result_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_o |-> (result_o == '0));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |=> ($stable(trial_o) && $stable(result_o) && eoc_o));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .trial_o  (trial_o),
  .result_o (result_o),
  .eoc_o    (eoc_o)
);

// File: tb/sar_conv_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb_top;
  localparam int W = 4;
  // input level in half-LSB units, and the code it must convert to
  localparam int VEC_N = 16;
  localparam int VEC_IN  [VEC_N] = '{0, 3, 4, 7, 8, 11, 12, 15, 16, 19, 20, 23, 24, 27, 28, 31};
  localparam int VEC_EXP [VEC_N] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   vin2 = 0;
  logic cmp;
  logic [W-1:0] trial, result;
  logic eoc;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  // ideal comparator: 1 when the input is at or above the DAC level
  always_comb cmp = (vin2 >= 2 * int'(trial));

  sar_conv_ctrl #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp),
    .trial_o(trial), .result_o(result), .eoc_o(eoc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_conv(input int v);
    @(negedge clk);
    rst_n = 1'b0;
    vin2  = v;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic walk_conv(input int v, input int expv);
    bit eoc_ok = 1'b1, zero_ok = 1'b1;
    start_conv(v);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k < 5) begin
        if (eoc !== 1'b0) eoc_ok = 1'b0;
        if (result !== '0) zero_ok = 1'b0;
      end else if (eoc !== 1'b1) eoc_ok = 1'b0;
    end
    check(eoc_ok, "R4 eoc on fifth edge", int'(eoc), 1);
    check(zero_ok, "R6 result zero before eoc", int'(result), 0);
    check(result == W'(expv), "R5 result code", int'(result), expv);
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(trial == '0 && result == '0 && eoc == 1'b0, "R1 reset state",
          int'({trial, result, eoc}), 0);

    // table walk over all 16 codes (R5, R4, R6)
    for (int n = 0; n < VEC_N; n++) walk_conv(VEC_IN[n], VEC_EXP[n]);

    // R2/R3: level 1010 traced edge by edge
    start_conv(20);
    @(negedge clk); check(trial == 4'b1000, "R2 first trial", int'(trial), 8);
    @(negedge clk); check(trial == 4'b1100, "R3 bit3 kept", int'(trial), 12);
    @(negedge clk); check(trial == 4'b1010, "R3 bit2 cleared", int'(trial), 10);
    @(negedge clk); check(trial == 4'b1011, "R3 bit1 kept", int'(trial), 11);
    @(negedge clk); check(trial == 4'b1010 && eoc, "R3 bit0 cleared", int'(trial), 10);
    check(result[3] == 1'b1 && result[0] == 1'b0, "R6 D3 is MSB", int'(result), 10);

    // R7: comparator swings after eoc have no effect
    vin2 = 31;
    repeat (3) @(negedge clk);
    check(result == 4'b1010 && trial == 4'b1010 && eoc, "R7 hold high level",
          int'(result), 10);
    vin2 = 0;
    repeat (3) @(negedge clk);
    check(result == 4'b1010 && trial == 4'b1010 && eoc, "R7 hold low level",
          int'(result), 10);

    // R8: no self restart, then a reset starts a fresh conversion
    vin2 = 9;
    repeat (10) @(negedge clk);
    check(result == 4'b1010 && eoc, "R8 no self restart", int'(result), 10);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(trial == '0 && result == '0 && eoc == 1'b0, "R1 reset clears after eoc",
          int'({trial, result, eoc}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(result == 4'b0100 && eoc, "R8 new conversion after reset", int'(result), 4);

    // extremes once more
    walk_conv(31, 15);
    walk_conv(0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule